// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical translations for a device-side IOMMU. Each line pairs a 7-bit address-space identifier and a 20-bit virtual page number (4 KB pages, so virtual address bits [31:12]) with a physical frame number and three permission bits. Requesters present an ASID and a 32-bit virtual address on the lookup port. One cycle later they receive hit, frame number and permissions. A page table walker writes new translations through the fill port.

Software uses a small register bus with two registers. The configuration register (address 0) sets how many lines are active. The invalidation register (address 1) takes one encoded command word. The command drops every entry, or only entries in one 4 MB section, or only entries in one 16 KB group. An optional qualifier restricts the command to a single ASID. Invalidation takes one cycle. Lines are replaced round-robin among the active lines only.

Top module: `asid_tlb`

## Requirements
- R1: After reset no lookup hits, and lk_hit, lk_pfn and lk_perm are all zero.
- R2: A filled translation hits for a lookup with the same ASID and virtual address bits [31:12], whatever bits [11:0] are. The hit returns the filled frame number and permissions, where permission bit 2 is readable, bit 1 is writable and bit 0 is nonsecure. A lookup with a different ASID misses.
- R3: Lookup results are registered: they appear in the cycle after lk_valid is sampled. A cycle without lk_valid produces hit 0 with frame number and permissions 0, and so does a miss.
- R4: An invalidation command with mode bits [1:0] = 0 and bit 31 clear invalidates every line.
- R5: When command bit 31 is set, only lines whose ASID equals command bits [30:24] are affected.
- R6: Mode 2 invalidates lines whose virtual page bits [19:10] (address bits [31:22]) equal command bits [19:10].
- R7: Mode 3 invalidates lines whose virtual page bits [19:2] (address bits [31:14]) equal command bits [19:2].
- R8: A lookup in the same cycle as an invalidation returns the result from the state before the invalidation.
- R9: A fill in the same cycle as an invalidation is discarded if the command matches the fill's ASID and page. It is kept otherwise.
- R10: Configuration bits [7:0] set the active line count, clamped to the line count. Only lines below the active count hit. New fills go round-robin into the active lines, so the (A+1)th distinct fill evicts the oldest of A active lines.
- R11: A fill whose ASID and page already sit in an active line overwrites that line in place and evicts nothing.
- R12: Mode 1 invalidates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space ID |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Registered hit |
| lk_pfn | output | PFN_W | Registered frame number (0 on miss) |
| lk_perm | output | 3 | Registered {readable, writable, nonsecure} |
| fill_valid | input | 1 | Fill request from the walker |
| fill_asid | input | 7 | Fill address-space ID |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_perm | input | 3 | Fill {readable, writable, nonsecure} |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = invalidation command |
| reg_wdata | input | 32 | Register write data |

## Verification
Two pairs of functions can land in the same cycle. An invalidation can meet a lookup, and it can meet a fill. The bench provokes both by driving the register write and the lookup or fill in one clock.

For the lookup case, the returned result must show the entry as it was before the invalidation, and a following probe must miss. For the fill case, a matching invalidation must drop the fill and a non-matching one must let it land. After each such cycle, a sweep over the whole tag pool compares every result against a reference model kept in the bench.

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb #(
  parameter int NUM_LINES = 8,
  parameter int PFN_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [6:0]       lk_asid,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [2:0]       lk_perm,
  input  logic             fill_valid,
  input  logic [6:0]       fill_asid,
  input  logic [19:0]      fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CNT_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0] vld;
  logic [6:0]           e_asid [NUM_LINES];
  logic [19:0]          e_vpn  [NUM_LINES];
  logic [PFN_W-1:0]     e_pfn  [NUM_LINES];
  logic [2:0]           e_perm [NUM_LINES];
  logic [CNT_W-1:0]     active;
  logic [IDX_W-1:0]     ptr;

  logic [NUM_LINES-1:0] lk_match, fill_same, kill;
  logic [IDX_W-1:0]     same_idx, victim;
  logic                 flush, fill_kill, fill_ok, has_same;
  logic [PFN_W-1:0]     sel_pfn;
  logic [2:0]           sel_perm;

  wire unused_bits = &{reg_wdata[23:20], lk_va[11:0]};

  function automatic logic cmd_hit(logic [31:0] c, logic [6:0] a, logic [19:0] v);
    logic addr_ok;
    case (c[1:0])
      2'd0:    addr_ok = 1'b1;
      2'd2:    addr_ok = (v[19:10] == c[19:10]);
      2'd3:    addr_ok = (v[19:2] == c[19:2]);
      default: addr_ok = 1'b0;
    endcase
    return addr_ok && (!c[31] || a == c[30:24]);
  endfunction

  assign flush     = reg_we && reg_addr;
  assign fill_kill = flush && cmd_hit(reg_wdata, fill_asid, fill_vpn);
  assign fill_ok   = fill_valid && (active != '0) && !fill_kill;
  assign has_same  = |fill_same;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    wire on = vld[i] && (CNT_W'(i) < active);
    assign lk_match[i]  = on && e_asid[i] == lk_asid && e_vpn[i] == lk_va[31:12];
    assign fill_same[i] = on && e_asid[i] == fill_asid && e_vpn[i] == fill_vpn;
    assign kill[i]      = flush && cmd_hit(reg_wdata, e_asid[i], e_vpn[i]);
  end

  always_comb begin
    same_idx = '0;
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (fill_same[i]) same_idx = IDX_W'(i);
      if (lk_match[i]) begin
        sel_pfn  = sel_pfn  | e_pfn[i];
        sel_perm = sel_perm | e_perm[i];
      end
    end
  end

  assign victim = has_same ? same_idx : ((CNT_W'(ptr) < active) ? ptr : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      active  <= CNT_W'(NUM_LINES);
      ptr     <= '0;
      lk_hit  <= 1'b0;
      lk_pfn  <= '0;
      lk_perm <= '0;
    end else begin
      lk_hit  <= lk_valid && |lk_match;
      lk_pfn  <= lk_valid ? sel_pfn  : '0;
      lk_perm <= lk_valid ? sel_perm : '0;
      if (reg_we && !reg_addr)
        active <= (int'(reg_wdata[7:0]) > NUM_LINES) ? CNT_W'(NUM_LINES)
                                                      : CNT_W'(reg_wdata[7:0]);
      for (int i = 0; i < NUM_LINES; i++)
        if (kill[i]) vld[i] <= 1'b0;
      if (fill_ok) begin
        vld[victim]    <= 1'b1;
        e_asid[victim] <= fill_asid;
        e_vpn[victim]  <= fill_vpn;
        e_pfn[victim]  <= fill_pfn;
        e_perm[victim] <= fill_perm;
        if (!has_same)
          ptr <= (CNT_W'(victim) + CNT_W'(1) >= active) ? '0 : victim + IDX_W'(1);
      end
    end
  end
endmodule

module asid_tlb_chk #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic          reg_we,
  input logic          reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          fill_valid,
  input logic [N-1:0]  vld,
  input logic [N-1:0]  lk_match,
  input logic [IW-1:0] victim,
  input logic [CW-1:0] active
);
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> vld == '0);
  a_r3_registered_result: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> !lk_hit);
  a_r4_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr && !reg_wdata[31] && reg_wdata[1:0] == 2'd0) |=> vld == '0);
  a_r10_victim_active: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && active != '0) |-> CW'(victim) < active);
  a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

bind asid_tlb asid_tlb_chk #(.N(NUM_LINES), .IW(IDX_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .fill_valid(fill_valid), .vld(vld), .lk_match(lk_match),
  .victim(victim), .active(active)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int N  = 8;
  localparam int PW = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, lk_valid, lk_hit, fill_valid, reg_we, reg_addr;
  logic [6:0] lk_asid, fill_asid;
  logic [31:0] lk_va, reg_wdata;
  logic [PW-1:0] lk_pfn, fill_pfn;
  logic [2:0] lk_perm, fill_perm;
  logic [19:0] fill_vpn;

  asid_tlb #(.NUM_LINES(N), .PFN_W(PW)) i_asid_tlb (.*);

  int vectors = 0, errors = 0;
  bit mv[N];
  logic [6:0] ma[N];
  logic [19:0] mvpn[N];
  logic [PW-1:0] mpfn[N];
  logic [2:0] mperm[N];
  int mptr = 0, mact = N;

  function automatic logic [6:0] p_asid(int i); return i[0] ? 7'd5 : 7'd9; endfunction
  function automatic logic [19:0] p_vpn(int i);
    return {8'h12, i[3:2], 7'h0, i[1], 2'b00};
  endfunction
  function automatic logic [PW-1:0] p_pfn(int i); return PW'(20'hA0000 + i * 17); endfunction
  function automatic logic [2:0] p_perm(int i); return i[2:0] ^ 3'b101; endfunction

  function automatic logic [31:0] c_all(bit u, logic [6:0] a);
    return {u, a, 22'h0, 2'd0};
  endfunction
  function automatic logic [31:0] c_sec(bit u, logic [6:0] a, logic [19:0] v);
    return {u, a, 4'h0, v[19:10], 8'h0, 2'd2};
  endfunction
  function automatic logic [31:0] c_grp(bit u, logic [6:0] a, logic [19:0] v);
    return {u, a, 4'h0, v[19:2], 2'd3};
  endfunction

  function automatic bit m_hit(logic [31:0] c, logic [6:0] a, logic [19:0] v);
    bit ok;
    case (c[1:0])
      2'd0: ok = 1;
      2'd2: ok = (v >> 10) == (c[19:0] >> 10);
      2'd3: ok = (v >> 2) == (c[19:0] >> 2);
      default: ok = 0;
    endcase
    return ok && (!c[31] || a == c[30:24]);
  endfunction

  task automatic cyc(bit lv, logic [6:0] la, logic [31:0] va,
                     bit fv, logic [6:0] fa, logic [19:0] fvp, logic [PW-1:0] fp, logic [2:0] fperm,
                     bit we, bit ad, logic [31:0] wd, string tag, bit chk);
    bit eh = 0; logic [PW-1:0] ep = '0; logic [2:0] er = '0;
    int same = -1, idx;
    bit fl = we && ad;
    @(negedge clk);
    lk_valid = lv; lk_asid = la; lk_va = va;
    fill_valid = fv; fill_asid = fa; fill_vpn = fvp; fill_pfn = fp; fill_perm = fperm;
    reg_we = we; reg_addr = ad; reg_wdata = wd;
    if (lv)
      for (int i = 0; i < mact; i++)
        if (mv[i] && ma[i] == la && mvpn[i] == va[31:12]) begin
          eh = 1; ep = mpfn[i]; er = mperm[i];
        end
    @(posedge clk);
    #1;
    for (int i = 0; i < mact; i++)
      if (same < 0 && mv[i] && ma[i] == fa && mvpn[i] == fvp) same = i;
    if (fl)
      for (int i = 0; i < N; i++)
        if (mv[i] && m_hit(wd, ma[i], mvpn[i])) mv[i] = 0;
    if (fv && mact != 0 && !(fl && m_hit(wd, fa, fvp))) begin
      if (same >= 0) idx = same;
      else begin
        idx = (mptr < mact) ? mptr : 0;
        mptr = (idx + 1 >= mact) ? 0 : idx + 1;
      end
      mv[idx] = 1; ma[idx] = fa; mvpn[idx] = fvp; mpfn[idx] = fp; mperm[idx] = fperm;
    end
    if (we && !ad) mact = (int'(wd[7:0]) > N) ? N : int'(wd[7:0]);
    if (chk) begin
      vectors++;
      if (lk_hit !== eh || lk_pfn !== ep || lk_perm !== er) begin
        errors++;
        $display("FAIL %s: asid=%0d va=%h got hit=%0b pfn=%h perm=%b exp hit=%0b pfn=%h perm=%b",
                 tag, la, va, lk_hit, lk_pfn, lk_perm, eh, ep, er);
      end
    end
    lk_valid = 0; fill_valid = 0; reg_we = 0;
  endtask

  task automatic fill(int i, logic [PW-1:0] pfn);
    cyc(0, 0, 0, 1, p_asid(i), p_vpn(i), pfn, p_perm(i), 0, 0, 0, "fill", 0);
  endtask
  task automatic wreg(bit ad, logic [31:0] d);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, ad, d, "reg", 0);
  endtask
  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) begin
      cyc(1, p_asid(i), {p_vpn(i), 12'h3A5}, 0, 0, 0, 0, 0, 0, 0, 0, tag, 1);
      cyc(1, p_asid(i) ^ 7'h40, {p_vpn(i), 12'h000}, 0, 0, 0, 0, 0, 0, 0, 0, tag, 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; lk_valid = 0; fill_valid = 0; reg_we = 0; reg_addr = 0;
    lk_asid = 0; lk_va = 0; fill_asid = 0; fill_vpn = 0; fill_pfn = 0; fill_perm = 0; reg_wdata = 0;
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    vectors++;
    if (lk_hit !== 0 || lk_pfn !== 0 || lk_perm !== 0) begin
      errors++;
      $display("FAIL R1: outputs after reset hit=%0b pfn=%h perm=%b exp 0", lk_hit, lk_pfn, lk_perm);
    end
    sweep("R1 empty after reset");
    for (int i = 0; i < 8; i++) fill(i, p_pfn(i));
    sweep("R2 lookup after fill");
    cyc(0, p_asid(0), {p_vpn(0), 12'h0}, 0, 0, 0, 0, 0, 0, 0, 0, "R3 idle lookup", 1);
    wreg(1, c_sec(1, 7'd5, p_vpn(4)));
    sweep("R6 R5 section with asid");
    wreg(1, c_grp(0, 0, p_vpn(2)));
    sweep("R7 group");
    wreg(1, {1'b0, 7'd0, 4'h0, p_vpn(0) >> 2, 2'd1});
    sweep("R12 reserved mode");
    wreg(1, c_all(1, 7'd9));
    sweep("R5 all with asid");
    for (int i = 0; i < 16; i++) fill(i, p_pfn(i));
    sweep("R10 round-robin eviction");
    fill(15, p_pfn(15) ^ 20'h00F0F);
    sweep("R11 overwrite in place");
    wreg(0, 32'd4);
    sweep("R10 inactive lines never hit");
    for (int i = 0; i < 6; i++) fill(i, p_pfn(i) + 20'd3);
    sweep("R10 fills in active lines");
    wreg(0, 32'd200);
    sweep("R10 clamped active count");
    cyc(1, p_asid(5), {p_vpn(5), 12'h0}, 0, 0, 0, 0, 0, 1, 1, c_all(0, 0), "R8 lookup with flush", 1);
    cyc(1, p_asid(5), {p_vpn(5), 12'h0}, 0, 0, 0, 0, 0, 0, 0, 0, "R8 after flush", 1);
    sweep("R4 flush all");
    cyc(0, 0, 0, 1, p_asid(3), p_vpn(3), p_pfn(3), p_perm(3), 1, 1, c_sec(0, 0, p_vpn(3)), "R9", 0);
    cyc(0, 0, 0, 1, p_asid(6), p_vpn(6), p_pfn(6), p_perm(6), 1, 1, c_grp(0, 0, p_vpn(0)), "R9", 0);
    sweep("R9 fill with flush");
    for (int i = 0; i < 10; i++) fill(i, p_pfn(i));
    wreg(1, c_all(0, 0));
    sweep("R4 flush all after refill");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule